// File: doc/BRIEF.md
# Cycle-by-Cycle Peak and Valley Current Limiter

This block sits between a voltage-mode PWM modulator and the gate commands of a synchronous buck stage. It receives the modulator's high-side request together with a strobe marking the start of each switching period. From these and a set of comparator outputs it produces the qualified high-side and low-side commands. The comparators report three things: a peak current sensed on the high-side switch, a valley current sensed on the low-side switch, and feedback against an over-voltage level and a power-good window. When no protection is active the request passes through unchanged, including the full-off and full-on extremes.

The two current comparators are each blanked for a set number of clocks after their own switch turns on, so that switching ringing is not taken as a fault. A peak fault cuts only the pulse in progress. A valley fault holds the high-side off, skipping whole periods, until the sensed current falls back under the limit. Over-voltage with hysteresis forces the low-side on. Every current fault gives a one-clock status pulse and advances a saturating event counter.

Top module: `cycle_current_limiter`

## Requirements
- R1: While reset is asserted, `hs_on_o`, `ls_on_o`, `skip_o`, `peak_trip_o`, `valley_trip_o`, `ov_o` and `pgood_o` are all 0 and `trip_cnt_o` is 0.
- R2: With no protection active, `hs_on_o` equals `pwm_req_i` one clock later and `ls_on_o` is its complement. A request held at 0 or held at 1 across cycle-start strobes passes through unchanged.
- R3: `peak_cmp_i` has no effect during the first `PEAK_BLANK` clocks in which `hs_on_o` is 1.
- R4: A peak fault seen after blanking drives `hs_on_o` to 0 on the next clock and pulses `peak_trip_o` on that same clock. The high-side stays off while the request stays high, until a clock in which `cyc_start_i` is 1.
- R5: `valley_cmp_i` has no effect during the first `VALLEY_BLANK` clocks in which `ls_on_o` is 1. A valley fault seen after blanking pulses `valley_trip_o` on the next clock.
- R6: After a valley fault, `hs_on_o` stays 0 for as long as `valley_cmp_i` stays 1, whatever the request and the cycle-start strobes do. It follows the request again on the clock after `valley_cmp_i` returns to 0.
- R7: `skip_o` pulses for one clock for each cycle-start strobe that arrives with the request high while the valley hold blocks the high-side.
- R8: Over-voltage sets when `ov_set_i` (feedback at or above 120% of reference) is 1 and clears only when `ov_hold_i` (feedback at or above 117%) is 0. While it is set, `ov_o` and `ls_on_o` are 1 and `hs_on_o` is 0, one clock after the inputs.
- R9: `pgood_o` is 1 one clock after `fb_over_min_i` (feedback above 90%) and `fb_under_max_i` (feedback below 110%) are both 1, and is 0 otherwise.
- R10: Each trip status pulse lasts exactly one clock. `trip_cnt_o` rises by one on each pulse and holds at all ones once it gets there.
- R11: `hs_on_o` and `ls_on_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_req_i | input | 1 | High-side request from the modulator |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching period |
| peak_cmp_i | input | 1 | High-side current above the peak limit |
| valley_cmp_i | input | 1 | Low-side current above the valley limit |
| ov_set_i | input | 1 | Feedback at or above the over-voltage set level |
| ov_hold_i | input | 1 | Feedback at or above the over-voltage release level |
| fb_over_min_i | input | 1 | Feedback above the lower power-good bound |
| fb_under_max_i | input | 1 | Feedback below the upper power-good bound |
| hs_on_o | output | 1 | Qualified high-side command |
| ls_on_o | output | 1 | Qualified low-side command |
| skip_o | output | 1 | Pulse: a period was skipped by the valley hold |
| peak_trip_o | output | 1 | Pulse: peak current fault |
| valley_trip_o | output | 1 | Pulse: valley current fault |
| ov_o | output | 1 | Over-voltage active |
| pgood_o | output | 1 | Feedback inside the power-good window |
| trip_cnt_o | output | CNT_W | Saturating count of current faults |

## Verification
The hardest cases to reach are the exact edge of each blanking window and the lasting valley hold. The first needs a comparator to rise in a chosen clock, counted from the moment its own switch turned on. The second needs cycle-start strobes arriving while the fault is still present. The bench sweeps the comparator's first asserted clock across and past each window on a small configuration. For every sweep it predicts when the fault pulse appears and how long the high-side stays on. After each valley fault it keeps the comparator high through several strobes, counting skipped periods before it releases the comparator. Fourteen faults in total drive the three-bit counter into saturation. The feedback level is swept up and back down through both over-voltage thresholds to exercise the hysteresis.

// File: rtl/limiter_pkg.sv
package limiter_pkg;

    // Registered control state of the current limiter.
    typedef struct packed {
        logic hs;     // high-side command
        logic ls;     // low-side command
        logic lock;   // peak fault: high-side off until next period
        logic hold;   // valley fault: high-side off while current high
        logic ov;     // over-voltage latched with hysteresis
        logic pg;     // power-good
        logic skip;   // skipped-period pulse
        logic ptrip;  // peak fault pulse
        logic vtrip;  // valley fault pulse
    } lim_state_t;

endpackage

// File: rtl/lim_blank_timer.sv
module lim_blank_timer #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic open_o
);
    localparam int CW = (LEN < 1) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!gate_i)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = cnt_q;
        else
            cnt_d = CW'(cnt_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Comparator is trusted once the switch has been on for LEN clocks.
    assign open_o = gate_i && (cnt_q == LAST);
endmodule

// File: rtl/lim_sat_counter.sv
module lim_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && !(&cnt_q))
            cnt_d = W'(cnt_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cycle_current_limiter.sv
module cycle_current_limiter
    import limiter_pkg::*;
#(
    parameter int PEAK_BLANK   = 10,
    parameter int VALLEY_BLANK = 40,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_req_i,
    input  logic             cyc_start_i,
    input  logic             peak_cmp_i,
    input  logic             valley_cmp_i,
    input  logic             ov_set_i,
    input  logic             ov_hold_i,
    input  logic             fb_over_min_i,
    input  logic             fb_under_max_i,
    output logic             hs_on_o,
    output logic             ls_on_o,
    output logic             skip_o,
    output logic             peak_trip_o,
    output logic             valley_trip_o,
    output logic             ov_o,
    output logic             pgood_o,
    output logic [CNT_W-1:0] trip_cnt_o
);
    lim_state_t st_d, st_q;

    logic peak_open, valley_open;
    logic peak_ev, valley_ev;

    // Each sensing path is blanked after its own switch turns on.
    lim_blank_timer #(.LEN(PEAK_BLANK)) u_peak_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (st_q.hs),
        .open_o (peak_open)
    );

    lim_blank_timer #(.LEN(VALLEY_BLANK)) u_valley_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (st_q.ls),
        .open_o (valley_open)
    );

    always_comb begin
        st_d = st_q;

        // Over-voltage: set at the upper level, release under the lower one.
        st_d.ov = st_q.ov ? ov_hold_i : ov_set_i;

        peak_ev   = st_q.hs && peak_open && peak_cmp_i;
        valley_ev = !st_q.hold && st_q.ls && valley_open && valley_cmp_i;

        // Peak fault ends the current pulse; a fault wins over a new period.
        if (peak_ev)
            st_d.lock = 1'b1;
        else if (cyc_start_i)
            st_d.lock = 1'b0;

        // Valley hold lasts while the low-side current stays above the limit.
        st_d.hold = st_q.hold ? valley_cmp_i : valley_ev;

        st_d.hs = pwm_req_i && !st_d.lock && !st_d.hold && !st_d.ov;
        st_d.ls = !st_d.hs;

        st_d.skip  = cyc_start_i && pwm_req_i && st_d.hold;
        st_d.ptrip = peak_ev;
        st_d.vtrip = valley_ev;
        st_d.pg    = fb_over_min_i && fb_under_max_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lim_sat_counter #(.W(CNT_W)) u_trip_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (peak_ev || valley_ev),
        .count_o (trip_cnt_o)
    );

    assign hs_on_o       = st_q.hs;
    assign ls_on_o       = st_q.ls;
    assign skip_o        = st_q.skip;
    assign peak_trip_o   = st_q.ptrip;
    assign valley_trip_o = st_q.vtrip;
    assign ov_o          = st_q.ov;
    assign pgood_o       = st_q.pg;
endmodule

// File: rtl/cycle_current_limiter_chk.sv
module cycle_current_limiter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_on_o,
    input logic             ls_on_o,
    input logic             skip_o,
    input logic             peak_trip_o,
    input logic             valley_trip_o,
    input logic             ov_o,
    input logic [CNT_W-1:0] trip_cnt_o
);
    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));

    // R3
    peak_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_trip_o |-> $past(hs_on_o));

    // R4
    peak_cuts_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_trip_o |-> !hs_on_o);

    // R5
    valley_needs_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_trip_o |-> $past(ls_on_o));

    // R6
    valley_blocks_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_trip_o |-> !hs_on_o);

    // R7
    skip_blocks_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> !hs_on_o);

    // R8
    ov_forces_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_o |-> (ls_on_o && !hs_on_o));

    // R10
    peak_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_trip_o |=> !peak_trip_o);

    // R10
    valley_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_trip_o |=> !valley_trip_o);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((peak_trip_o || valley_trip_o) && !(&$past(trip_cnt_o)))
            |-> (trip_cnt_o == CNT_W'($past(trip_cnt_o) + 1'b1)));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(peak_trip_o || valley_trip_o) |-> $stable(trip_cnt_o));
endmodule

bind cycle_current_limiter cycle_current_limiter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_on_o       (hs_on_o),
    .ls_on_o       (ls_on_o),
    .skip_o        (skip_o),
    .peak_trip_o   (peak_trip_o),
    .valley_trip_o (valley_trip_o),
    .ov_o          (ov_o),
    .trip_cnt_o    (trip_cnt_o)
);

// File: tb/cycle_current_limiter_tb.sv
module cycle_current_limiter_tb;
    localparam int CLK_P = 10;
    localparam int PB    = 3;
    localparam int VB    = 5;
    localparam int CW    = 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0, cyc_start = 1'b0, peak_cmp = 1'b0, valley_cmp = 1'b0;
    logic ov_set = 1'b0, ov_hold = 1'b0, fb_lo_ok = 1'b0, fb_hi_ok = 1'b0;
    logic hs, ls, skip, ptrip, vtrip, ov, pgood;
    logic [CW-1:0] tcnt;

    int n_chk = 0;
    int n_fail = 0;
    int trips = 0;

    always #(CLK_P/2) clk = ~clk;

    cycle_current_limiter #(.PEAK_BLANK(PB), .VALLEY_BLANK(VB), .CNT_W(CW)) u_dut (
        .clk (clk), .rst_n (rst_n), .pwm_req_i (pwm_req), .cyc_start_i (cyc_start),
        .peak_cmp_i (peak_cmp), .valley_cmp_i (valley_cmp), .ov_set_i (ov_set),
        .ov_hold_i (ov_hold), .fb_over_min_i (fb_lo_ok), .fb_under_max_i (fb_hi_ok),
        .hs_on_o (hs), .ls_on_o (ls), .skip_o (skip), .peak_trip_o (ptrip),
        .valley_trip_o (vtrip), .ov_o (ov), .pgood_o (pgood), .trip_cnt_o (tcnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_level(input int p);
        ov_set   = (p >= 120);
        ov_hold  = (p >= 117);
        fb_lo_ok = (p > 90);
        fb_hi_ok = (p < 110);
    endtask

    task automatic check_count();
        int e;
        e = (trips > CMAX) ? CMAX : trips;
        chk(int'(tcnt) == e, "R10 saturating count", int'(tcnt), e);
    endtask

    task automatic peak_case(input int j);
        int on_cnt, first, pulses, m;
        pwm_req = 1'b0; peak_cmp = 1'b0; valley_cmp = 1'b0; cyc_start = 1'b0;
        cyc(3);
        pwm_req = 1'b1; cyc_start = 1'b1;
        on_cnt = 0; first = -1; pulses = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            if (hs) on_cnt++;
            if (ptrip) begin
                pulses++;
                if (first < 0) first = k;
            end
            peak_cmp = (k >= j);
        end
        m = (j > PB) ? j : PB;
        chk(on_cnt == m + 1, "R3 high-side on-time with blanking", on_cnt, m + 1);
        chk(first == m + 1, "R4 peak trip clock", first, m + 1);
        chk(pulses == 1, "R10 peak pulse count", pulses, 1);
        peak_cmp = 1'b0;
        cyc(3);
        chk(hs == 1'b0, "R4 high-side held off until period start", int'(hs), 0);
        trips++;
        check_count();
        cyc_start = 1'b1;
        cyc(1);
        cyc_start = 1'b0;
        chk(hs == 1'b1, "R4 high-side restarts at period start", int'(hs), 1);
    endtask

    task automatic valley_case(input int j);
        int first, pulses, m, skips, hs_seen;
        peak_cmp = 1'b0; valley_cmp = 1'b0;
        pwm_req = 1'b1; cyc_start = 1'b1;
        cyc(1);
        cyc_start = 1'b0;
        cyc(2);
        pwm_req = 1'b0;
        first = -1; pulses = 0; hs_seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (hs) hs_seen++;
            if (vtrip) begin
                pulses++;
                if (first < 0) first = k;
            end
            valley_cmp = (k >= j);
        end
        m = (j > VB) ? j : VB;
        chk(first == m + 1, "R5 valley trip clock with blanking", first, m + 1);
        chk(pulses == 1, "R10 valley pulse count", pulses, 1);
        trips++;
        check_count();
        pwm_req = 1'b1;
        skips = 0;
        for (int s = 0; s < 3; s++) begin
            cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
            if (skip) skips++;
            if (hs) hs_seen++;
            @(negedge clk);
            if (skip) skips++;
            if (hs) hs_seen++;
        end
        chk(skips == 3, "R7 skipped periods", skips, 3);
        chk(hs_seen == 0, "R6 high-side held during valley fault", hs_seen, 0);
        valley_cmp = 1'b0;
        cyc(1);
        chk(hs == 1'b1, "R6 release after valley clears", int'(hs), 1);
    endtask

    initial begin
        int p;
        bit exp_ov, exp_pg, prev_req, req;
        set_level(100);
        cyc(2);
        chk(hs == 1'b0, "R1 reset hs", int'(hs), 0);
        chk(ls == 1'b0, "R1 reset ls", int'(ls), 0);
        chk((skip | ptrip | vtrip | ov | pgood) == 1'b0, "R1 reset status", 1, 0);
        chk(tcnt == '0, "R1 reset count", int'(tcnt), 0);
        rst_n = 1'b1;
        cyc(2);

        // R2: full-off, full-on across period starts, then a mixed pattern
        prev_req = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(hs == prev_req, "R2 high-side follows request", int'(hs), int'(prev_req));
                chk(ls == !prev_req, "R2 low-side complement", int'(ls), int'(!prev_req));
            end
            req = (i < 20) ? 1'b0 : (i < 40) ? 1'b1 : ((i % 3) == 0);
            pwm_req = req;
            cyc_start = ((i % 5) == 0);
            prev_req = req;
        end
        cyc_start = 1'b0;

        for (int j = 0; j <= PB + 2; j++) peak_case(j);
        for (int j = 0; j <= VB + 2; j++) valley_case(j);
        chk(int'(tcnt) == CMAX, "R10 counter saturated", int'(tcnt), CMAX);

        // R8 / R9: feedback level swept up then down
        pwm_req = 1'b1; cyc_start = 1'b0; peak_cmp = 1'b0; valley_cmp = 1'b0;
        set_level(100);
        exp_ov = 1'b0; exp_pg = 1'b1;
        cyc(1);
        for (int i = 0; i < 94; i++) begin
            @(negedge clk);
            chk(ov == exp_ov, "R8 over-voltage state", int'(ov), int'(exp_ov));
            chk(hs == !exp_ov, "R8 high-side under over-voltage", int'(hs), int'(!exp_ov));
            chk(ls == exp_ov, "R8 low-side under over-voltage", int'(ls), int'(exp_ov));
            chk(pgood == exp_pg, "R9 power-good window", int'(pgood), int'(exp_pg));
            p = (i < 47) ? (80 + i) : (126 - (i - 47));
            set_level(p);
            exp_ov = exp_ov ? (p >= 117) : (p >= 120);
            exp_pg = (p > 90) && (p < 110);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule